// File: doc/BRIEF.md
# Branch and Call Sequencer

This block decides where a small 16-bit processor continues after a control-transfer instruction. The code address is 24 bits: a 16-bit program offset and an 8-bit code bank. The instruction decoder presents an operation code, a condition code, the current status flags, and the operands. These are the accumulator, a 24-bit immediate or operand address, an 8-bit displacement and the address of the following instruction. It then pulses `start`. The sequencer evaluates the condition and forms the target. For calls it writes the return information to the stack. For indirect forms it reads the destination from memory. When the new offset and bank are valid, it raises `done` for one cycle.

Stack writes and destination reads use a single word-wide port with a request/ready handshake. The block keeps its request and its address and data steady until `memReady` is seen. The stack pointer lives inside the block and moves down by two for every word written. The block never writes the status flags; they are input only.

Top module: `branch_seq`

## Requirements
- R1: After reset `pcOut` equals `RST_PC`, `bankOut` equals `RST_BANK`, `spOut` equals `RST_SP`, and `done`, `busy` and `memReq` are low. No memory request is made while the block is idle.
- R2: With `op`=0 (conditional), `cond[3:1]` selects the test: 0 Z, 1 C, 2 N, 3 V, 4 T, 5 V^N, 6 (V^N)|Z, 7 C|Z. `cond[0]`=1 inverts the test. The flags are `flags[0]`=Z, `[1]`=C, `[2]`=N, `[3]`=V, `[4]`=T.
- R3: A relative branch that is taken (including `op`=1, unconditional) raises `done` in the third cycle counting the start cycle as the first. A branch that is not taken, and the register and immediate forms, raise `done` in the second cycle.
- R4: A taken relative branch loads `nextPc` plus the sign-extended `disp`, wrapping within 16 bits. A branch that is not taken loads `nextPc`. The bank is unchanged in both cases.
- R5: `op`=2 loads the offset from `accIn` and keeps the bank.
- R6: The near forms keep the bank. `op`=3 and `op`=8 take the offset from `opnd[15:0]`. `op`=4 and `op`=7 take it from the word read at `opnd`.
- R7: The far indirect forms (`op`=5 and `op`=9) read the offset at `opnd` first. They then read the word at `opnd`+2 (24-bit wrap), and its low byte becomes the bank.
- R8: The far immediate forms (`op`=6 and `op`=10) load the offset from `opnd[15:0]` and the bank from `opnd[23:16]`.
- R9: A near call (`op`=7, 8) writes `nextPc` to address `spOut`-2 (upper address byte zero). The stack pointer then ends two lower.
- R10: A far call (`op`=9, 10) first writes the zero-extended bank to `spOut`-2, then `nextPc` to `spOut`-4. The stack pointer ends four lower.
- R11: A call through memory completes all of its stack writes before its first destination read.
- R12: While `memReq` is high and `memReady` is low, the request, write enable, address and write data hold their values. Each word takes one cycle plus the number of stalled cycles.
- R13: `done` lasts one cycle, occurs once per operation, and coincides with the new `pcOut` and `bankOut` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation presented on the other inputs (taken while idle) |
| op | input | 4 | Operation code 0..10 |
| cond | input | 4 | Condition select and invert bit |
| flags | input | 5 | Status flags {T,V,N,C,Z} |
| accIn | input | PC_W | Accumulator value |
| opnd | input | PC_W+BANK_W | Immediate target or operand address |
| disp | input | DISP_W | Signed relative displacement |
| nextPc | input | PC_W | Offset of the following instruction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | New offset and bank valid (one cycle) |
| pcOut | output | PC_W | Program offset |
| bankOut | output | BANK_W | Code bank |
| spOut | output | PC_W | Stack pointer |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Request is a write |
| memAddr | output | PC_W+BANK_W | Word address |
| memWdata | output | PC_W | Write data |
| memRdata | input | PC_W | Read data |
| memReady | input | 1 | Transfer completes at this edge |

## Verification
The bench builds the block with a 16-bit offset, an 8-bit bank, an 8-bit displacement, reset offset 0x1000 and reset stack pointer 0x0800. With these values, displacements of either sign can wrap the offset past 0xFFFF and below 0x0000 inside one bank. A far indirect operand at 0x03FFFE places the bank word across the 16-bit boundary of the 24-bit address. The memory model inserts zero to three ready stalls per word, so back-to-back writes and the handover from pushes to reads are exercised under both immediate and delayed completion.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

  typedef enum logic [3:0] {
    OP_BCC   = 4'd0,
    OP_BRA   = 4'd1,
    OP_JACC  = 4'd2,
    OP_JIMM  = 4'd3,
    OP_JMEM  = 4'd4,
    OP_JFMEM = 4'd5,
    OP_JFIMM = 4'd6,
    OP_CMEM  = 4'd7,
    OP_CIMM  = 4'd8,
    OP_CFMEM = 4'd9,
    OP_CFIMM = 4'd10
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;     // capture operands and first target
    logic taken;     // relative branch goes to displaced target
    logic memWr;     // current transfer is a stack write
    logic pushBank;  // write data is the bank word
    logic pushAdv;   // stack write completes, step pointer
    logic rdSel;     // address second operand word
    logic rdLo;      // capture offset from read data
    logic rdHi;      // capture bank from read data
    logic commit;    // new offset and bank take effect
  } dpStrobe_t;

  function automatic logic condMet(input logic [3:0] c, input logic [4:0] f);
    logic z, cy, n, v, t, base;
    {t, v, n, cy, z} = f;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = t;
      3'd5: base = v ^ n;
      3'd6: base = (v ^ n) | z;
      default: base = cy | z;
    endcase
    return base ^ c[0];
  endfunction

  function automatic logic [1:0] pushWords(input opKind_e o);
    case (o)
      OP_CIMM, OP_CMEM:   return 2'd1;
      OP_CFIMM, OP_CFMEM: return 2'd2;
      default:            return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] readWords(input opKind_e o);
    case (o)
      OP_JMEM, OP_CMEM:   return 2'd1;
      OP_JFMEM, OP_CFMEM: return 2'd2;
      default:            return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import branch_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] op,
  input  logic [3:0] cond,
  input  logic [4:0] flags,
  input  logic       memReady,
  output dpStrobe_t  strb,
  output logic       memReq,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PUSH, S_READ} state_e;

  state_e  state, nxt;
  opKind_e opQ, opCur;
  logic    idx, doneQ;
  logic    lastPush, lastRead;

  assign opCur    = opKind_e'(op);
  assign lastPush = (pushWords(opQ) == ({1'b0, idx} + 2'd1));
  assign lastRead = (readWords(opQ) == ({1'b0, idx} + 2'd1));

  always_comb begin
    strb   = '0;
    nxt    = state;
    memReq = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.latch = 1'b1;
          if (opCur == OP_BCC)      strb.taken = condMet(cond, flags);
          else if (opCur == OP_BRA) strb.taken = 1'b1;
          if (strb.taken)                    nxt = S_WAIT;
          else if (pushWords(opCur) != 2'd0) nxt = S_PUSH;
          else if (readWords(opCur) != 2'd0) nxt = S_READ;
          else                               strb.commit = 1'b1;
        end
      end
      S_WAIT: begin
        strb.commit = 1'b1;
        nxt = S_IDLE;
      end
      S_PUSH: begin
        memReq        = 1'b1;
        strb.memWr    = 1'b1;
        strb.pushBank = (pushWords(opQ) == 2'd2) && !idx;
        if (memReady) begin
          strb.pushAdv = 1'b1;
          if (lastPush) begin
            if (readWords(opQ) != 2'd0) nxt = S_READ;
            else begin
              strb.commit = 1'b1;
              nxt = S_IDLE;
            end
          end
        end
      end
      default: begin
        memReq     = 1'b1;
        strb.rdSel = idx;
        if (memReady) begin
          strb.rdLo = !idx;
          strb.rdHi = idx;
          if (lastRead) begin
            strb.commit = 1'b1;
            nxt = S_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_BCC;
      idx   <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= strb.commit;
      if (strb.latch) opQ <= opCur;
      if (state != nxt)             idx <= 1'b0;
      else if (memReq && memReady)  idx <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/bseq_dp.sv
module bseq_dp
  import branch_seq_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          BANK_W   = 8,
  parameter int          DISP_W   = 8,
  parameter int unsigned RST_PC   = 'h1000,
  parameter int unsigned RST_BANK = 'h00,
  parameter int unsigned RST_SP   = 'h0800,
  localparam int         ADDR_W   = PC_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [3:0]        op,
  input  logic [PC_W-1:0]   accIn,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   nextPc,
  input  logic [PC_W-1:0]   memRdata,
  output logic [PC_W-1:0]   pcOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [PC_W-1:0]   spOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PC_W-1:0]   memWdata
);

  logic [PC_W-1:0]   pcQ, spQ, tgtPcQ, retQ, tgtPcN, relTgt, spDec;
  logic [BANK_W-1:0] bankQ, tgtBankQ, tgtBankN;
  logic [ADDR_W-1:0] eaQ;

  assign relTgt = nextPc + {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign spDec  = spQ - PC_W'(2);

  always_comb begin
    tgtPcN   = tgtPcQ;
    tgtBankN = tgtBankQ;
    if (strb.latch) begin
      tgtPcN   = pcQ;
      tgtBankN = bankQ;
      case (opKind_e'(op))
        OP_BCC, OP_BRA:     tgtPcN = strb.taken ? relTgt : nextPc;
        OP_JACC:            tgtPcN = accIn;
        OP_JIMM, OP_CIMM:   tgtPcN = opnd[PC_W-1:0];
        OP_JFIMM, OP_CFIMM: begin
          tgtPcN   = opnd[PC_W-1:0];
          tgtBankN = opnd[ADDR_W-1:PC_W];
        end
        default: ;
      endcase
    end
    if (strb.rdLo) tgtPcN   = memRdata;
    if (strb.rdHi) tgtBankN = memRdata[BANK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= PC_W'(RST_PC);
      bankQ    <= BANK_W'(RST_BANK);
      spQ      <= PC_W'(RST_SP);
      tgtPcQ   <= '0;
      tgtBankQ <= '0;
      retQ     <= '0;
      eaQ      <= '0;
    end else begin
      tgtPcQ   <= tgtPcN;
      tgtBankQ <= tgtBankN;
      if (strb.latch) begin
        retQ <= nextPc;
        eaQ  <= opnd;
      end
      if (strb.pushAdv) spQ <= spDec;
      if (strb.commit) begin
        pcQ   <= tgtPcN;
        bankQ <= tgtBankN;
      end
    end
  end

  assign memAddr  = strb.memWr ? {{BANK_W{1'b0}}, spDec}
                               : eaQ + (strb.rdSel ? ADDR_W'(2) : ADDR_W'(0));
  assign memWdata = strb.pushBank ? {{(PC_W-BANK_W){1'b0}}, bankQ} : retQ;

  assign pcOut   = pcQ;
  assign bankOut = bankQ;
  assign spOut   = spQ;

endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          BANK_W   = 8,
  parameter int          DISP_W   = 8,
  parameter int unsigned RST_PC   = 'h1000,
  parameter int unsigned RST_BANK = 'h00,
  parameter int unsigned RST_SP   = 'h0800,
  localparam int         ADDR_W   = PC_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [3:0]        cond,
  input  logic [4:0]        flags,
  input  logic [PC_W-1:0]   accIn,
  input  logic [ADDR_W-1:0] opnd,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   nextPc,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   pcOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [PC_W-1:0]   spOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PC_W-1:0]   memWdata,
  input  logic [PC_W-1:0]   memRdata,
  input  logic              memReady
);

  dpStrobe_t strb;

  bseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .cond(cond),
    .flags(flags), .memReady(memReady), .strb(strb), .memReq(memReq),
    .busy(busy), .done(done)
  );

  bseq_dp #(
    .PC_W(PC_W), .BANK_W(BANK_W), .DISP_W(DISP_W),
    .RST_PC(RST_PC), .RST_BANK(RST_BANK), .RST_SP(RST_SP)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .op(op), .accIn(accIn),
    .opnd(opnd), .disp(disp), .nextPc(nextPc), .memRdata(memRdata),
    .pcOut(pcOut), .bankOut(bankOut), .spOut(spOut),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memWe = strb.memWr;

endmodule

// File: rtl/bseq_check.sv
module bseq_check
  import branch_seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BANK_W = 8,
  localparam int ADDR_W = PC_W + BANK_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [3:0]        op,
  input logic [3:0]        cond,
  input logic [4:0]        flags,
  input logic              busy,
  input logic              done,
  input logic [BANK_W-1:0] bankOut,
  input logic [PC_W-1:0]   spOut,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PC_W-1:0]   memWdata
);

  opKind_e           opSeen;
  logic              takenSeen;
  logic [BANK_W-1:0] bankAtStart;
  logic [7:0]        cycCnt;
  logic              relOp, farOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSeen      <= OP_BCC;
      takenSeen   <= 1'b0;
      bankAtStart <= '0;
      cycCnt      <= '0;
    end else if (start && !busy) begin
      opSeen      <= opKind_e'(op);
      takenSeen   <= (opKind_e'(op) == OP_BRA) ||
                     ((opKind_e'(op) == OP_BCC) && condMet(cond, flags));
      bankAtStart <= bankOut;
      cycCnt      <= 8'd2;
    end else if (cycCnt != 8'hFF) begin
      cycCnt <= cycCnt + 8'd1;
    end
  end

  assign relOp = (opSeen == OP_BCC) || (opSeen == OP_BRA);
  assign farOp = (opSeen == OP_JFMEM) || (opSeen == OP_JFIMM) ||
                 (opSeen == OP_CFMEM) || (opSeen == OP_CFIMM);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  assert_rel_cycles_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && relOp) |-> (cycCnt == (takenSeen ? 8'd3 : 8'd2)));

  assert_near_bank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !farOp) |-> (bankOut == bankAtStart));

  assert_sp_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memReady) |=> (spOut == $past(spOut) - PC_W'(2)));

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=>
      (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind branch_seq bseq_check #(.PC_W(PC_W), .BANK_W(BANK_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .op(op), .cond(cond), .flags(flags),
  .busy(busy), .done(done), .bankOut(bankOut), .spOut(spOut),
  .memReq(memReq), .memWe(memWe), .memReady(memReady),
  .memAddr(memAddr), .memWdata(memWdata)
);

// File: tb/branch_seq_test.sv
module branch_seq_test;

  localparam int PC_W = 16, BANK_W = 8, DISP_W = 8, ADDR_W = 24;
  localparam logic [15:0] RPC = 16'h1000, RSP = 16'h0800;
  localparam logic [7:0]  RBANK = 8'h00;

  logic clk = 0, rstN = 0, start = 0, memReady = 0;
  logic [3:0] op = 0, cond = 0;
  logic [4:0] flags = 0;
  logic [15:0] accIn = 0, nextPc = 0, memRdata = 0;
  logic [23:0] opnd = 0;
  logic [7:0] disp = 0;
  logic busy, done, memReq, memWe;
  logic [15:0] pcOut, spOut, memWdata;
  logic [7:0] bankOut;
  logic [23:0] memAddr;

  branch_seq #(.PC_W(PC_W), .BANK_W(BANK_W), .DISP_W(DISP_W),
               .RST_PC(32'h1000), .RST_BANK(32'h00), .RST_SP(32'h0800)) uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .cond(cond), .flags(flags),
    .accIn(accIn), .opnd(opnd), .disp(disp), .nextPc(nextPc), .busy(busy),
    .done(done), .pcOut(pcOut), .bankOut(bankOut), .spOut(spOut),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  always #5 clk = ~clk;

  typedef struct packed { logic we; logic [23:0] addr; logic [15:0] data; } memItem_t;
  typedef struct packed { logic [15:0] pc; logic [7:0] bank; logic [15:0] sp; logic [15:0] cyc; } resItem_t;

  memItem_t memQ[$];
  string    memTagQ[$];
  resItem_t resQ[$];
  string    resTagQ[$];

  int checks = 0, failures = 0, cyc = 0, startCyc = 0, stallCfg = 0, waitCnt = 0;
  bit doneFlag = 0;
  logic [15:0] mPc = RPC, mSp = RSP;
  logic [7:0]  mBank = RBANK;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memVal(input logic [23:0] a);
    return a[15:0] ^ 16'h3C5A ^ {a[23:16], a[23:16]};
  endfunction

  function automatic bit expCond(input logic [3:0] c, input logic [4:0] f);
    bit r;
    case (c[3:1])
      3'd0: r = f[0];
      3'd1: r = f[1];
      3'd2: r = f[2];
      3'd3: r = f[3];
      3'd4: r = f[4];
      3'd5: r = f[3] ^ f[2];
      3'd6: r = (f[3] ^ f[2]) | f[0];
      default: r = f[1] | f[0];
    endcase
    return r ^ c[0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready after stallCfg idle cycles per word
  always begin
    @(posedge clk); #2;
    if (memReq) begin
      if (waitCnt >= stallCfg) begin
        memReady = 1; memRdata = memVal(memAddr); waitCnt = 0;
      end else begin
        memReady = 0; waitCnt++;
      end
    end else begin
      memReady = 0; waitCnt = 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN && memReq && memReady) begin
      if (memQ.size() == 0) check(0, "R11 unexpected transfer", {39'd0, memWe, memAddr}, 64'd0);
      else begin
        memItem_t e; string t;
        e = memQ.pop_front(); t = memTagQ.pop_front();
        check(memWe == e.we && memAddr == e.addr && (!e.we || memWdata == e.data), t,
              {23'd0, memWe, memAddr, memWdata}, {23'd0, e.we, e.addr, e.data});
      end
    end
    if (rstN && done) begin
      if (resQ.size() == 0) check(0, "R13 extra done", 64'd1, 64'd0);
      else begin
        resItem_t e; string t; logic [15:0] n;
        e = resQ.pop_front(); t = resTagQ.pop_front();
        n = 16'(cyc - startCyc + 1);
        check(pcOut == e.pc && bankOut == e.bank && spOut == e.sp && n == e.cyc, t,
              {pcOut, bankOut, spOut, n}, {e.pc, e.bank, e.sp, e.cyc});
      end
      doneFlag = 1;
    end
  end

  task automatic exec(input logic [3:0] o, input logic [3:0] c, input logic [4:0] f,
                      input logic [15:0] a, input logic [23:0] opd, input logic [7:0] d,
                      input logic [15:0] nx, input int stall, input string tag);
    int nPush, nRead, n;
    bit tk;
    resItem_t r;
    nPush = (o == 4'd7 || o == 4'd8) ? 1 : (o == 4'd9 || o == 4'd10) ? 2 : 0;
    nRead = (o == 4'd4 || o == 4'd7) ? 1 : (o == 4'd5 || o == 4'd9) ? 2 : 0;
    tk = (o == 4'd1) || (o == 4'd0 && expCond(c, f));
    if (nPush == 2) begin
      memQ.push_back({1'b1, 8'h00, 16'(mSp - 16'd2), {8'h00, mBank}}); memTagQ.push_back({tag, " bank push"});
      mSp = mSp - 16'd2;
    end
    if (nPush >= 1) begin
      memQ.push_back({1'b1, 8'h00, 16'(mSp - 16'd2), nx}); memTagQ.push_back({tag, " pc push"});
      mSp = mSp - 16'd2;
    end
    case (o)
      4'd0, 4'd1: mPc = tk ? 16'(nx + {{8{d[7]}}, d}) : nx;
      4'd2: mPc = a;
      4'd3, 4'd8: mPc = opd[15:0];
      4'd6, 4'd10: begin mPc = opd[15:0]; mBank = opd[23:16]; end
      default: ;
    endcase
    if (nRead >= 1) begin
      memQ.push_back({1'b0, opd, 16'h0}); memTagQ.push_back({tag, " offset read"});
      mPc = memVal(opd);
    end
    if (nRead == 2) begin
      memQ.push_back({1'b0, 24'(opd + 24'd2), 16'h0}); memTagQ.push_back({tag, " bank read"});
      mBank = memVal(24'(opd + 24'd2))[7:0];
    end
    n = tk ? 3 : 2 + (nPush + nRead) * (stall + 1);
    r = {mPc, mBank, mSp, 16'(n)};
    resQ.push_back(r); resTagQ.push_back(tag);
    stallCfg = stall;
    @(posedge clk); #2;
    op = o; cond = c; flags = f; accIn = a; opnd = opd; disp = d; nextPc = nx;
    start = 1; startCyc = cyc; doneFlag = 0;
    @(posedge clk); #2;
    start = 0;
    while (!doneFlag) @(posedge clk);
    doneFlag = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] pats [6] = '{5'h00, 5'h1F, 5'h05, 5'h0A, 5'h12, 5'h08};
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(pcOut == RPC && bankOut == RBANK && spOut == RSP, "R1 reset regs",
          {pcOut, bankOut, spOut}, {RPC, RBANK, RSP});
    check(!done && !busy && !memReq, "R1 reset controls", {done, busy, memReq}, 3'b000);

    // R2 R3 R4: all sixteen conditions over several flag patterns
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 6; k++)
        exec(4'd0, 4'(c), pats[k], 16'h0, 24'h0, 8'(c * 13 + k * 37), 16'(16'h4000 + c * 16 + k),
             0, "R2/R3/R4 cond");
    // R4 wrap both ways
    exec(4'd0, 4'd0, 5'h01, 16'h0, 24'h0, 8'hF0, 16'h0005, 0, "R4 wrap down");
    exec(4'd1, 4'd0, 5'h00, 16'h0, 24'h0, 8'h10, 16'hFFFE, 0, "R3/R4 wrap up");
    // R8 far immediate jump, then near forms keep bank
    exec(4'd6, 4'd0, 5'h00, 16'h0, 24'h5A1234, 8'h0, 16'h1111, 0, "R8 far imm");
    exec(4'd2, 4'd0, 5'h1F, 16'hBEEF, 24'h0, 8'h0, 16'h2000, 0, "R5 acc jump");
    exec(4'd3, 4'd0, 5'h00, 16'h0, 24'hFF2222, 8'h0, 16'h2002, 0, "R6 near imm");
    exec(4'd1, 4'd0, 5'h00, 16'h0, 24'h0, 8'h80, 16'h0040, 0, "R4 bank kept");
    exec(4'd4, 4'd0, 5'h00, 16'h0, 24'h120100, 8'h0, 16'h2004, 1, "R6/R12 near mem");
    // R7 far indirect across the 16-bit boundary
    exec(4'd5, 4'd0, 5'h00, 16'h0, 24'h03FFFE, 8'h0, 16'h2006, 2, "R7/R12 far mem");
    // calls
    exec(4'd8, 4'd0, 5'h00, 16'h0, 24'h003300, 8'h0, 16'h3002, 0, "R9 near call");
    exec(4'd7, 4'd0, 5'h00, 16'h0, 24'h210400, 8'h0, 16'h3004, 3, "R9/R11/R12 near mem call");
    exec(4'd10, 4'd0, 5'h00, 16'h0, 24'h7E0500, 8'h0, 16'h3006, 0, "R10 far call");
    exec(4'd9, 4'd0, 5'h00, 16'h0, 24'h440600, 8'h0, 16'h3008, 2, "R10/R11/R12 far mem call");
    exec(4'd10, 4'd0, 5'h00, 16'h0, 24'h010700, 8'h0, 16'h300A, 1, "R10/R12 far call stall");

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(memQ.size() == 0 && resQ.size() == 0, "R11/R13 leftover items",
          64'(memQ.size() + resQ.size()), 64'd0);
    check(!busy && !memReq, "R1 idle quiet", {busy, memReq}, 2'b00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule